// File: doc/BRIEF.md
# NAND Flash Bus Cycle Front End

This block sits between a simple processor-side register port and an asynchronous NAND flash bus. Host accesses fall into one of two areas, selected by the top address bit. The register area holds three registers: a control register with one NAND-mode enable per chipselect, a status register that reports the synchronised ready/busy wait line, and a read-only revision register. The data window turns each host access into NAND bus cycles. Two address bits of the access choose whether those cycles latch a command, latch an address, or move data.

A host access of 8, 16 or 32 bits becomes one, two or four byte cycles, least significant byte first. Every byte cycle drives the chip-enable and the latch signals for one clock of setup, then holds the write or read strobe low for a fixed number of clocks, then keeps it high for one clock of hold. The host holds its request until a single-cycle done pulse. For a read, the assembled word is valid during that pulse. A mask over the access address drives a second chip-enable, which selects the second die of a stacked package.

Top module: `nand_cycle_front`

## Requirements
- R1: A data-window access with byte-address bit 3 set and bit 4 clear drives `nandAle` high and `nandCle` low on every byte cycle.
- R2: A data-window access with bit 4 set drives `nandCle` high and `nandAle` low, even if bit 3 is also set. With both bits clear, every byte cycle is a plain data cycle with both latch signals low.
- R3: `hostSize` values 0, 1 and 2 (and 3, treated as 2) give 1, 2 and 4 byte write cycles. Byte k carries `hostWdata[8k+7:8k]`. All byte cycles of one access have the same latch state. Address bits 1:0 have no effect.
- R4: A read of n bytes returns byte k of the NAND data in `hostRdata[8k+7:8k]`, with unused upper bytes zero. The data is valid while `hostDone` is high, and `hostDone` is high for exactly one cycle.
- R5: Address bit 15 set selects the data window, and bits 14:13 select the chipselect. Control register bits 3:0 (register index 0, address bits 3:2) enable NAND mode per chipselect, and they read back with the upper bits zero. A data-window access to a disabled chipselect makes no NAND cycle, finishes one cycle after acceptance, and reads zero.
- R6: When the access address has any bit of `SEC_MASK` set (default bit 12), `nandCe2N` is low during its byte cycles, and it is high otherwise.
- R7: Status register (index 1) bit 0 returns `nandWait` (1 means ready) through a two-flop synchroniser. All other status bits read zero.
- R8: Revision register (index 2) reads `{16'h0, REV_MAJOR, REV_MINOR}`, and writes to it have no effect.
- R9: Each byte cycle holds chip-enable low for one setup clock, then `STROBE_CLKS` clocks of strobe low, then one hold clock. An n-byte NAND access raises `hostDone` n*(STROBE_CLKS+2)+1 clocks after the accepting edge, and a register access raises it one clock after. A read samples `nandDqI` on the last strobe-low clock.
- R10: At most one primary chip-enable is low at a time, and `nandWeN` and `nandReN` are never low together. `nandDqOe` is high only during write cycles.
- R11: During and after reset, and with no access in progress, all chip-enables and both strobes are high, `hostDone` is low, and the control register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, held until `hostDone` |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| hostAddr | input | ADDR_W | Byte address of the access |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data, valid with `hostDone` |
| hostDone | output | 1 | One-cycle completion pulse |
| nandCeN | output | NUM_CS | Active-low chip-enables |
| nandCe2N | output | 1 | Active-low secondary chip-enable |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandReN | output | 1 | Active-low read strobe |
| nandDqO | output | 8 | Data bus output |
| nandDqOe | output | 1 | Data bus output enable |
| nandDqI | input | 8 | Data bus input |
| nandWait | input | 1 | Wired-AND ready/busy, 1 = ready |

## Verification
The result of an access is due at a fixed clock count after the accepting edge: one clock for register and disabled-chipselect accesses, and n*(STROBE_CLKS+2)+1 clocks for an n-byte NAND access. The bench counts clocks from the edge that accepts the request and requires `hostDone` at exactly that count. It reads the returned data in that same cycle. Each byte cycle is logged on the falling clock edge after its strobe rises, which is the hold clock, when the latch signals, chip-enables and data lines are still driven. The strobe width is counted in falling edges. A status read follows a change of `nandWait` only after several idle clocks, which covers the two-flop synchroniser.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;     // request taken this edge
    logic regOp;      // access completes without bus cycles
    logic nextByte;   // advance to the next byte lane
    logic capture;    // sample read data this edge
    logic busCycle;   // a byte cycle is on the bus
    logic strobeLow;  // strobe phase
  } cycStrobe_t;

endpackage

// File: rtl/nand_cyc_ctrl.sv
module nand_cyc_ctrl
  import nand_front_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int NB_W        = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostReq,
  input  logic            goNand,
  input  logic [NB_W-1:0] numBytes,
  output cycStrobe_t      st,
  output logic            hostDone
);

  localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

  phase_e          phase;
  logic [CNT_W-1:0] strobeCnt;
  logic [NB_W-1:0]  bytesLeft;

  always_comb begin
    st.busCycle  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    st.strobeLow = (phase == PH_STROBE);
    st.accept    = (phase == PH_IDLE) && hostReq;
    st.regOp     = st.accept && !goNand;
    st.capture   = (phase == PH_STROBE) && (strobeCnt == CNT_LAST);
    st.nextByte  = (phase == PH_HOLD) && (bytesLeft != '0);
    hostDone     = (phase == PH_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      strobeCnt <= '0;
      bytesLeft <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (hostReq) begin
            if (goNand) begin
              phase     <= PH_SETUP;
              bytesLeft <= numBytes - NB_W'(1);
            end else begin
              phase <= PH_DONE;
            end
          end
        end
        PH_SETUP: begin
          phase     <= PH_STROBE;
          strobeCnt <= '0;
        end
        PH_STROBE: begin
          if (strobeCnt == CNT_LAST) phase <= PH_HOLD;
          else strobeCnt <= strobeCnt + CNT_W'(1);
        end
        PH_HOLD: begin
          if (bytesLeft == '0) begin
            phase <= PH_DONE;
          end else begin
            bytesLeft <= bytesLeft - NB_W'(1);
            phase     <= PH_SETUP;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_cyc_datapath.sv
module nand_cyc_datapath
  import nand_front_pkg::*;
#(
  parameter int          NUM_CS    = 4,
  parameter int          ADDR_W    = 16,
  parameter int          HOST_W    = 32,
  parameter int          NB_W      = 3,
  parameter int          WIN_BIT   = 15,
  parameter int          CS_LSB    = 13,
  parameter int          ALE_BIT   = 3,
  parameter int          CLE_BIT   = 4,
  parameter logic [ADDR_W-1:0] SEC_MASK = 16'h1000,
  parameter logic [7:0]  REV_MAJOR = 8'h02,
  parameter logic [7:0]  REV_MINOR = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  cycStrobe_t        st,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              goNand,
  output logic [NB_W-1:0]   numBytes,
  output logic [NUM_CS-1:0] nandCeN,
  output logic              nandCe2N,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDqO,
  output logic              nandDqOe,
  input  logic [7:0]        nandDqI,
  input  logic              nandWait
);

  localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int LANES   = HOST_W / 8;
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic [NUM_CS-1:0] ctrlReg;
  logic [1:0]        waitSync;
  logic [ADDR_W-1:0] addrLat;
  logic              wrLat;
  logic [HOST_W-1:0] wdLat;
  logic [HOST_W-1:0] rdReg;
  logic [LANE_W-1:0] byteIdx;
  logic [HOST_W-1:0] regView;
  logic [CS_W-1:0]   csSel;
  logic [CS_W-1:0]   csLat;
  logic [1:0]        regIdx;

  // request decode
  always_comb begin
    csSel  = hostAddr[CS_LSB +: CS_W];
    regIdx = hostAddr[3:2];
    goNand = hostAddr[WIN_BIT] && ctrlReg[csSel];
    unique case (hostSize)
      2'd0:    numBytes = NB_W'(1);
      2'd1:    numBytes = NB_W'(2);
      default: numBytes = NB_W'(LANES);
    endcase
    unique case (regIdx)
      2'd0:    regView = HOST_W'(ctrlReg);
      2'd1:    regView = HOST_W'(waitSync[1]);
      2'd2:    regView = HOST_W'({REV_MAJOR, REV_MINOR});
      default: regView = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitSync <= 2'b00;
    else       waitSync <= {waitSync[0], nandWait};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      addrLat <= '0;
      wrLat   <= 1'b0;
      wdLat   <= '0;
      rdReg   <= '0;
      byteIdx <= '0;
    end else begin
      if (st.accept) begin
        addrLat <= hostAddr;
        wrLat   <= hostWe;
        wdLat   <= hostWdata;
        byteIdx <= '0;
        rdReg   <= '0;
        if (st.regOp && !hostAddr[WIN_BIT]) begin
          if (hostWe && regIdx == 2'd0) ctrlReg <= hostWdata[NUM_CS-1:0];
          if (!hostWe) rdReg <= regView;
        end
      end
      if (st.nextByte) byteIdx <= byteIdx + LANE_W'(1);
      if (st.capture && !wrLat) rdReg[byteIdx*8 +: 8] <= nandDqI;
    end
  end

  // bus pins
  always_comb begin
    csLat     = addrLat[CS_LSB +: CS_W];
    nandCeN   = st.busCycle ? ~(NUM_CS'(1) << csLat) : '1;
    nandCe2N  = !(st.busCycle && ((addrLat & SEC_MASK) != '0));
    nandCle   = st.busCycle && addrLat[CLE_BIT];
    nandAle   = st.busCycle && addrLat[ALE_BIT] && !addrLat[CLE_BIT];
    nandWeN   = !(st.strobeLow && wrLat);
    nandReN   = !(st.strobeLow && !wrLat);
    nandDqOe  = st.busCycle && wrLat;
    nandDqO   = wdLat[byteIdx*8 +: 8];
    hostRdata = rdReg;
  end

endmodule

// File: rtl/nand_cycle_front.sv
module nand_cycle_front
  import nand_front_pkg::*;
#(
  parameter int          NUM_CS      = 4,
  parameter int          ADDR_W      = 16,
  parameter int          STROBE_CLKS = 3,
  parameter logic [ADDR_W-1:0] SEC_MASK = 16'h1000,
  parameter logic [7:0]  REV_MAJOR   = 8'h02,
  parameter logic [7:0]  REV_MINOR   = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostDone,
  output logic [NUM_CS-1:0] nandCeN,
  output logic              nandCe2N,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDqO,
  output logic              nandDqOe,
  input  logic [7:0]        nandDqI,
  input  logic              nandWait
);

  localparam int HOST_W = 32;
  localparam int NB_W   = $clog2(HOST_W / 8) + 1;

  cycStrobe_t      st;
  logic            goNand;
  logic [NB_W-1:0] numBytes;

  nand_cyc_ctrl #(
    .STROBE_CLKS(STROBE_CLKS),
    .NB_W       (NB_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostReq (hostReq),
    .goNand  (goNand),
    .numBytes(numBytes),
    .st      (st),
    .hostDone(hostDone)
  );

  nand_cyc_datapath #(
    .NUM_CS   (NUM_CS),
    .ADDR_W   (ADDR_W),
    .HOST_W   (HOST_W),
    .NB_W     (NB_W),
    .SEC_MASK (SEC_MASK),
    .REV_MAJOR(REV_MAJOR),
    .REV_MINOR(REV_MINOR)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .hostWe   (hostWe),
    .hostSize (hostSize),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .goNand   (goNand),
    .numBytes (numBytes),
    .nandCeN  (nandCeN),
    .nandCe2N (nandCe2N),
    .nandCle  (nandCle),
    .nandAle  (nandAle),
    .nandWeN  (nandWeN),
    .nandReN  (nandReN),
    .nandDqO  (nandDqO),
    .nandDqOe (nandDqOe),
    .nandDqI  (nandDqI),
    .nandWait (nandWait)
  );

endmodule

// File: rtl/nand_cycle_front_chk.sv
module nand_cycle_front_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostDone,
  input logic [NUM_CS-1:0] nandCeN,
  input logic              nandCe2N,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic [7:0]        nandDqO,
  input logic              nandDqOe
);

  p_ce_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~nandCeN));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  p_dq_oe_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    nandDqOe |-> nandReN);

  p_strobe_in_ce_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> (nandCeN != '1));

  p_setup_before_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nandWeN) || $fell(nandReN)) |-> ($past(nandCeN) != '1));

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(nandAle && nandCle));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  p_dq_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> $stable(nandDqO));

  p_ce2_in_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !nandCe2N |-> (nandCeN != '1));

endmodule

bind nand_cycle_front nand_cycle_front_chk #(.NUM_CS(NUM_CS)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hostDone(hostDone),
  .nandCeN (nandCeN),
  .nandCe2N(nandCe2N),
  .nandCle (nandCle),
  .nandAle (nandAle),
  .nandWeN (nandWeN),
  .nandReN (nandReN),
  .nandDqO (nandDqO),
  .nandDqOe(nandDqOe)
);

// File: tb/test_nand_cycle_front.sv
`timescale 1ns/1ps
module test_nand_cycle_front;

  localparam int STROBE = 3;
  localparam int NVEC   = 11;

  // {we, size, addr, wdata}
  localparam logic [50:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 16'h8010, 32'h0000_00FF},  // command latch
    {1'b1, 2'd0, 16'h8008, 32'h0000_0012},  // address latch
    {1'b1, 2'd2, 16'h8008, 32'h4433_2211},  // four address bytes
    {1'b1, 2'd1, 16'h8000, 32'h0000_BEEF},  // two data bytes
    {1'b1, 2'd2, 16'h8003, 32'hCAFE_F00D},  // low bits ignored
    {1'b1, 2'd0, 16'h8018, 32'h0000_005A},  // both bits: command wins
    {1'b1, 2'd1, 16'h9000, 32'h0000_1234},  // secondary enable
    {1'b1, 2'd3, 16'hA010, 32'h8877_6655},  // chipselect 1, size 3
    {1'b0, 2'd2, 16'h8000, 32'h0},          // word read
    {1'b0, 2'd1, 16'hA002, 32'h0},          // halfword read, cs1
    {1'b0, 2'd0, 16'h9000, 32'h0}           // byte read, second die
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [15:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostDone;
  logic [3:0]  nandCeN;
  logic        nandCe2N, nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [7:0]  nandDqO;
  logic [7:0]  rdModel = 8'h30;
  logic        nandWait = 1'b0;

  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  nand_cycle_front i_nand_cycle_front (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostDone(hostDone), .nandCeN(nandCeN),
    .nandCe2N(nandCe2N), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDqO(nandDqO),
    .nandDqOe(nandDqOe), .nandDqI(rdModel), .nandWait(nandWait)
  );

  // bus monitor: logs each byte cycle in its hold clock
  logic [7:0] logDq  [8];
  logic [3:0] logCe  [8];
  logic       logAle [8], logCle [8], logCe2 [8];
  int         logW [8];
  int         wrCount = 0, rdCount = 0, lowCnt = 0;
  logic       prevWe = 1'b1, prevRe = 1'b1;

  always @(negedge clk) begin
    if (!nandWeN || !nandReN) lowCnt = lowCnt + 1;
    if (!prevWe && nandWeN && wrCount < 8) begin
      logDq[wrCount] = nandDqO; logCe[wrCount] = ~nandCeN;
      logAle[wrCount] = nandAle; logCle[wrCount] = nandCle;
      logCe2[wrCount] = !nandCe2N; logW[wrCount] = lowCnt;
      wrCount = wrCount + 1; lowCnt = 0;
    end
    if (!prevRe && nandReN && rdCount < 8) begin
      logCe[rdCount] = ~nandCeN; logCe2[rdCount] = !nandCe2N;
      logW[rdCount] = lowCnt;
      rdCount = rdCount + 1; lowCnt = 0;
      rdModel = rdModel + 8'd1;
    end
    prevWe = nandWeN; prevRe = nandReN;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic we, input logic [1:0] sz, input logic [15:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    wrCount = 0; rdCount = 0; lowCnt = 0;
    hostReq = 1'b1; hostWe = we; hostSize = sz; hostAddr = a; hostWdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!hostDone && lat < 2000);
    rd = hostRdata;
    hostReq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog (R9) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd, exp;
    int lat, n;
    logic [7:0] seed;

    repeat (3) @(negedge clk);
    // R11: reset state
    check(nandCeN == 4'hF && nandWeN && nandReN && !hostDone && nandCe2N,
          "R11 reset pins", {nandCeN, nandWeN, nandReN, hostDone}, {4'hF, 1'b1, 1'b1, 1'b0});
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(nandCeN == 4'hF && nandWeN && nandReN && !hostDone,
          "R11 idle pins", {nandCeN, nandWeN, nandReN, hostDone}, {4'hF, 1'b1, 1'b1, 1'b0});
    doAccess(1'b0, 2'd2, 16'h0000, 32'h0, rd, lat);
    check(rd == 32'h0, "R11 control reg after reset", rd, 32'h0);
    check(lat == 1, "R9 register latency", lat, 1);

    // R5: disabled chipselect makes no cycle
    doAccess(1'b1, 2'd2, 16'h8000, 32'h1111_1111, rd, lat);
    check(lat == 1 && wrCount == 0, "R5 disabled cs write", {lat[15:0], wrCount[15:0]}, {16'd1, 16'd0});

    // R5: enable chipselects 0 and 1, upper bits dropped
    doAccess(1'b1, 2'd2, 16'h0000, 32'hFFFF_FFF3, rd, lat);
    doAccess(1'b0, 2'd2, 16'h0000, 32'h0, rd, lat);
    check(rd == 32'h3, "R5 control readback", rd, 32'h3);

    // R8: revision value and write ignored
    doAccess(1'b1, 2'd2, 16'h0008, 32'hFFFF_FFFF, rd, lat);
    doAccess(1'b0, 2'd2, 16'h0008, 32'h0, rd, lat);
    check(rd == 32'h0000_0205, "R8 revision", rd, 32'h0000_0205);
    doAccess(1'b0, 2'd2, 16'h0000, 32'h0, rd, lat);
    check(rd == 32'h3, "R8 revision write left control alone", rd, 32'h3);

    // R7: status follows wait through the synchroniser
    doAccess(1'b0, 2'd2, 16'h0004, 32'h0, rd, lat);
    check(rd == 32'h0, "R7 status busy", rd, 32'h0);
    nandWait = 1'b1;
    repeat (4) @(negedge clk);
    doAccess(1'b0, 2'd2, 16'h0004, 32'h0, rd, lat);
    check(rd == 32'h1, "R7 status ready", rd, 32'h1);

    // vector table
    seed = 8'h30;
    for (int v = 0; v < NVEC; v++) begin
      logic        we;
      logic [1:0]  sz;
      logic [15:0] a;
      logic [31:0] wd;
      {we, sz, a, wd} = VEC[v];
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      doAccess(we, sz, a, wd, rd, lat);
      check(lat == n * (STROBE + 2) + 1, "R9 access latency", lat, n * (STROBE + 2) + 1);
      if (we) begin
        check(wrCount == n, "R3 byte cycle count", wrCount, n);
        for (int k = 0; k < n && k < wrCount; k++) begin
          check(logDq[k] == wd[8*k +: 8], "R3 byte order", logDq[k], wd[8*k +: 8]);
          check(logAle[k] == (a[3] && !a[4]), "R1 ALE state", logAle[k], a[3] && !a[4]);
          check(logCle[k] == a[4], "R2 CLE state", logCle[k], a[4]);
          check(logCe2[k] == a[12], "R6 secondary enable", logCe2[k], a[12]);
          check(logCe[k] == (4'b1 << a[14:13]), "R10 chip enable", logCe[k], 4'b1 << a[14:13]);
          check(logW[k] == STROBE, "R9 strobe width", logW[k], STROBE);
        end
      end else begin
        exp = '0;
        for (int k = 0; k < n; k++) exp[8*k +: 8] = seed + 8'(k);
        seed = seed + 8'(n);
        check(rdCount == n, "R4 read byte count", rdCount, n);
        check(rd == exp, "R4 read assembly", rd, exp);
        check(logCe2[0] == a[12], "R6 secondary enable on read", logCe2[0], a[12]);
        check(logW[0] == STROBE, "R9 read strobe width", logW[0], STROBE);
      end
    end

    // R5: disabled chipselect read returns zero
    doAccess(1'b0, 2'd2, 16'hC000, 32'h0, rd, lat);
    check(rd == 32'h0 && rdCount == 0 && lat == 1, "R5 disabled cs read",
          {rd[15:0], rdCount[7:0], lat[7:0]}, 32'h0000_0001);

    // R11: idle after traffic, reset clears control
    @(negedge clk);
    check(nandCeN == 4'hF && nandWeN && nandReN, "R11 idle after traffic",
          {nandCeN, nandWeN, nandReN}, {4'hF, 1'b1, 1'b1});
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doAccess(1'b0, 2'd2, 16'h0000, 32'h0, rd, lat);
    check(rd == 32'h0, "R11 control cleared by reset", rd, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule